// File: doc/BRIEF.md
# Receive Line Decoder with Alarm Muting

This block sits between the clock-and-data recovery of an E1 receiver and the terminal equipment. It takes the recovered positive-mark and negative-mark streams, along with the recovered clock as a level, and works in a fast system clock domain. It brings the recovered clock in through a small synchronizer and samples a symbol on each rising edge of that clock. Every symbol goes through a four-position window before it is released. In dual-rail mode both rails pass through the window unchanged. In single-rail mode a small polarity-tracking state machine decodes the marks as AMI or HDB3. The decoded data goes out on the positive output, and the negative output carries a code-violation flag.

The output stage picks the output edge and the output polarity. It applies the forced levels for muting and for the alarm test, and it drives the loss-of-signal and loss-of-clock outputs.

The polarity tracker has three states. `PS_NONE` is the state after reset, when no mark has been seen. `PS_POS` means the last mark was positive, and `PS_NEG` means it was negative. Its transitions are:

- `PS_NONE` to `PS_POS` or `PS_NEG` on the first mark.
- `PS_POS` to `PS_NEG` on a negative mark, and `PS_NEG` to `PS_POS` on a positive mark.
- A self-loop on a mark whose polarity equals the last one. This is a bipolar violation.

A cycle with no sample, or a sampled zero, leaves the state unchanged.

Top module: `rx_line_decoder`

## Requirements
- R1: In dual-rail mode (`dual_rail_i`=1, `inv_pol_i`=0), a sampled symbol with `rx_pos_i`=1 appears as `rd_pos_o`=1, and one with `rx_neg_i`=1 appears as `rd_neg_o`=1.
- R2: A symbol is sampled on a rising edge of `rclk_i`, counted as bit period k. With the non-inverted timing it is presented from the falling edge of `rclk_i` in period k+3. With the inverted timing it is presented from the rising edge in period k+4. `rd_pos_o` changes only at the selected edge of `rclk_o`, unless a control input changes.
- R3: In single-rail HDB3 mode (`dual_rail_i`=0, `hdb3_i`=1), a valid substitution is decoded to zero data. The substitution is a mark of the same polarity as the previous mark, preceded by either three decoded zeros or by a mark followed by two zeros. The mark itself and the three positions before it all become zero.
- R4: In single-rail HDB3 mode, a same-polarity mark that does not fit either substitution pattern gives data 1, and `rd_neg_o`=1 in the same bit position.
- R5: In single-rail AMI mode (`hdb3_i`=0), every mark gives data 1. Each mark with the same polarity as the previous mark also gives `rd_neg_o`=1 in its bit position.
- R6: `inv_pol_i`=1 in dual-rail mode makes both data outputs active-low and selects the rising-edge timing. In single-rail mode `inv_pol_i` has no effect.
- R7: With `mute_en_i`=1 and `sig_lost_i`=1 in dual-rail mode with `inv_pol_i`=0, the outputs are forced to `rclk_o`=1, `rd_pos_o`=0 and `rd_neg_o`=0.
- R8: With `mute_en_i`=1 and `sig_lost_i`=1 in dual-rail mode with `inv_pol_i`=1, the outputs are forced to `rclk_o`=0, `rd_pos_o`=1 and `rd_neg_o`=1.
- R9: With `mute_en_i`=1 and `sig_lost_i`=1 in single-rail mode, the outputs are forced to `rclk_o`=1 and `rd_pos_o`=0.
- R10: `los_n_o` is the inverse of `sig_lost_i`. `loc_n_o` is low exactly when muting is enabled and the signal is lost; it is high otherwise.
- R11: With `alm_test_n_i`=0, `los_n_o` and `loc_n_o` are driven to 0. In single-rail mode `rd_neg_o` is also driven to 1, and this wins over muting. The data on `rd_pos_o` is unaffected.
- R12: After reset, with no mark received and no alarm, both data outputs are at their inactive level, `rclk_o`=0, and `los_n_o`=`loc_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rclk_i | input | 1 | Recovered clock as a level |
| rx_pos_i | input | 1 | Recovered positive mark |
| rx_neg_i | input | 1 | Recovered negative mark |
| dual_rail_i | input | 1 | 1 selects dual-rail mode, 0 selects single-rail mode |
| hdb3_i | input | 1 | Single-rail code: 1 selects HDB3, 0 selects AMI |
| inv_pol_i | input | 1 | Dual-rail active-low outputs with rising-edge timing |
| mute_en_i | input | 1 | Enables muting on loss of signal |
| sig_lost_i | input | 1 | Loss of signal from the line detector |
| alm_test_n_i | input | 1 | Alarm test, active low |
| rclk_o | output | 1 | Receive clock to the terminal equipment |
| rd_pos_o | output | 1 | Positive data, or decoded data in single-rail mode |
| rd_neg_o | output | 1 | Negative data, or violation flag in single-rail mode |
| los_n_o | output | 1 | Loss of signal, active low |
| loc_n_o | output | 1 | Loss of clock, active low |

## Verification
A symbol driven in bit period k is checked at the end of period k+3 with the falling-edge timing, and at the end of period k+4 with the rising-edge timing. Each end-of-period sample lies four system cycles after the last output update edge. By then the synchronizer, the edge detector and the output register have all settled, and the next sampling edge has not yet arrived. Muting, the alarm test and the loss outputs are combinational overrides. They are checked one cycle after the control changes, while the recovered clock is held low, so that a forced 1 on the clock output is distinct from its idle level.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    // One window slot: positive rail (or decoded data), negative rail, violation flag
    typedef struct packed {
        logic p;
        logic n;
        logic viol;
    } rxd_sym_t;

    // Polarity of the most recent mark
    typedef enum logic [1:0] {
        PS_NONE = 2'd0,
        PS_POS  = 2'd1,
        PS_NEG  = 2'd2
    } rxd_pol_e;

    // Positions held before release; HDB3 substitutions span four bits
    localparam int WIN_DEPTH = 4;
    localparam int SUB_SPAN  = WIN_DEPTH - 1;
endpackage

// File: rtl/rxd_edge_sync.sv
module rxd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o,
    output logic lvl_q_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   dly;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= lvl_i;
                else chain[g] <= chain[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly <= 1'b0;
        else        dly <= chain[SYNC_STAGES-1];
    end

    assign rise_o  = chain[SYNC_STAGES-1] & ~dly;
    assign fall_o  = ~chain[SYNC_STAGES-1] & dly;
    assign lvl_q_o = dly;
endmodule

// File: rtl/rxd_window.sv
module rxd_window
    import rxd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     shift_en,
    input  logic     in_pos,
    input  logic     in_neg,
    input  logic     dual_rail,
    input  logic     hdb3_en,
    output rxd_sym_t tail_o
);
    rxd_pol_e state, state_nx;
    rxd_sym_t win    [WIN_DEPTH];
    rxd_sym_t win_nx [WIN_DEPTH];

    logic is_mark, neg_only, same_pol, pat_zero, pat_bzz, valid_sub;
    rxd_sym_t new_sym;

    assign is_mark  = in_pos | in_neg;
    assign neg_only = in_neg & ~in_pos;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_NONE;
        else        state <= state_nx;
    end

    // Transition and violation decode
    always_comb begin
        same_pol = 1'b0;
        state_nx = state;
        unique case (state)
            PS_NONE: same_pol = 1'b0;
            PS_POS:  same_pol = is_mark & ~neg_only;
            PS_NEG:  same_pol = is_mark & neg_only;
            default: same_pol = 1'b0;
        endcase
        if (shift_en && is_mark) state_nx = neg_only ? PS_NEG : PS_POS;
    end

    assign pat_zero  = ~win[0].p & ~win[1].p & ~win[2].p;
    assign pat_bzz   =  win[2].p & ~win[1].p & ~win[0].p;
    assign valid_sub = hdb3_en & same_pol & (pat_zero | pat_bzz);

    always_comb begin
        if (dual_rail) begin
            new_sym = '{p: in_pos, n: in_neg, viol: 1'b0};
        end else begin
            new_sym = '{p: is_mark & ~valid_sub, n: 1'b0,
                        viol: same_pol & ~valid_sub};
        end
        win_nx[0] = new_sym;
        for (int i = 1; i < WIN_DEPTH; i++) begin
            win_nx[i] = win[i-1];
            if (!dual_rail && valid_sub && i <= SUB_SPAN) win_nx[i].p = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_DEPTH; i++) win[i] <= '0;
        end else if (shift_en) begin
            for (int i = 0; i < WIN_DEPTH; i++) win[i] <= win_nx[i];
        end
    end

    assign tail_o = win[WIN_DEPTH-1];
endmodule

// File: rtl/rxd_out_stage.sv
module rxd_out_stage
    import rxd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rise,
    input  logic     fall,
    input  logic     clk_lvl,
    input  rxd_sym_t tail,
    input  logic     dual_rail,
    input  logic     inv_pol,
    input  logic     mute_en,
    input  logic     sig_lost,
    input  logic     alm_test_n,
    output logic     rclk_o,
    output logic     rd_pos_o,
    output logic     rd_neg_o,
    output logic     los_n_o,
    output logic     loc_n_o
);
    logic inv_eff, out_stb, muted, q_pos, q_neg;

    assign inv_eff = dual_rail & inv_pol;
    assign out_stb = inv_eff ? rise : fall;
    assign muted   = mute_en & sig_lost;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_pos <= 1'b0;
            q_neg <= 1'b0;
        end else if (out_stb) begin
            q_pos <= tail.p;
            q_neg <= dual_rail ? tail.n : tail.viol;
        end
    end

    always_comb begin
        rclk_o   = muted ? ~inv_eff : clk_lvl;
        rd_pos_o = muted ? inv_eff : (q_pos ^ inv_eff);
        if (!dual_rail && !alm_test_n) rd_neg_o = 1'b1;
        else                           rd_neg_o = muted ? inv_eff : (q_neg ^ inv_eff);
        los_n_o  = ~sig_lost & alm_test_n;
        loc_n_o  = ~muted & alm_test_n;
    end
endmodule

// File: rtl/rx_line_decoder.sv
module rx_line_decoder
    import rxd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_i,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    input  logic dual_rail_i,
    input  logic hdb3_i,
    input  logic inv_pol_i,
    input  logic mute_en_i,
    input  logic sig_lost_i,
    input  logic alm_test_n_i,
    output logic rclk_o,
    output logic rd_pos_o,
    output logic rd_neg_o,
    output logic los_n_o,
    output logic loc_n_o
);
    logic     rise, fall, clk_lvl;
    rxd_sym_t tail;

    rxd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lvl_i(rclk_i),
        .rise_o(rise), .fall_o(fall), .lvl_q_o(clk_lvl)
    );

    rxd_window u_win (
        .clk(clk), .rst_n(rst_n), .shift_en(rise),
        .in_pos(rx_pos_i), .in_neg(rx_neg_i),
        .dual_rail(dual_rail_i), .hdb3_en(hdb3_i), .tail_o(tail)
    );

    rxd_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .clk_lvl(clk_lvl), .tail(tail), .dual_rail(dual_rail_i),
        .inv_pol(inv_pol_i), .mute_en(mute_en_i), .sig_lost(sig_lost_i),
        .alm_test_n(alm_test_n_i), .rclk_o(rclk_o), .rd_pos_o(rd_pos_o),
        .rd_neg_o(rd_neg_o), .los_n_o(los_n_o), .loc_n_o(loc_n_o)
    );
endmodule

// File: rtl/rx_line_decoder_chk.sv
module rx_line_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic dual_rail_i,
    input logic inv_pol_i,
    input logic mute_en_i,
    input logic sig_lost_i,
    input logic alm_test_n_i,
    input logic rclk_o,
    input logic rd_pos_o,
    input logic rd_neg_o,
    input logic los_n_o,
    input logic loc_n_o
);
    // R11: alarm test pulls both alarm outputs low
    p_alarm_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_test_n_i |-> (!los_n_o && !loc_n_o));

    // R7: muted dual-rail, normal polarity
    p_mute_dual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_en_i && sig_lost_i && dual_rail_i && !inv_pol_i)
        |-> (rclk_o && !rd_pos_o && !rd_neg_o));

    // R8: muted dual-rail, inverted polarity
    p_mute_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_en_i && sig_lost_i && dual_rail_i && inv_pol_i)
        |-> (!rclk_o && rd_pos_o && rd_neg_o));

    // R10: loss of clock never asserted without loss of signal or alarm test
    p_loc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_n_o && alm_test_n_i) |-> (sig_lost_i && mute_en_i));

    // R2: data changes only at the falling output clock edge (normal timing)
    p_fall_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_pos_o) && $stable(mute_en_i) && $stable(sig_lost_i)
         && $stable(dual_rail_i) && $stable(inv_pol_i) && !(dual_rail_i && inv_pol_i))
        |-> $fell(rclk_o));

    // R6: data changes only at the rising output clock edge (inverted timing)
    p_rise_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_pos_o) && $stable(mute_en_i) && $stable(sig_lost_i)
         && $stable(dual_rail_i) && $stable(inv_pol_i) && dual_rail_i && inv_pol_i)
        |-> $rose(rclk_o));
endmodule

bind rx_line_decoder rx_line_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dual_rail_i(dual_rail_i), .inv_pol_i(inv_pol_i),
    .mute_en_i(mute_en_i), .sig_lost_i(sig_lost_i), .alm_test_n_i(alm_test_n_i),
    .rclk_o(rclk_o), .rd_pos_o(rd_pos_o), .rd_neg_o(rd_neg_o),
    .los_n_o(los_n_o), .loc_n_o(loc_n_o)
);

// File: tb/rx_line_decoder_bench.sv
module rx_line_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rclk_i = 1'b0, rx_pos_i = 1'b0, rx_neg_i = 1'b0;
    logic dual_rail_i = 1'b0, hdb3_i = 1'b1, inv_pol_i = 1'b0;
    logic mute_en_i = 1'b0, sig_lost_i = 1'b0, alm_test_n_i = 1'b1;
    logic rclk_o, rd_pos_o, rd_neg_o, los_n_o, loc_n_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rx_line_decoder u_rx_line_decoder (
        .clk(clk), .rst_n(rst_n), .rclk_i(rclk_i), .rx_pos_i(rx_pos_i),
        .rx_neg_i(rx_neg_i), .dual_rail_i(dual_rail_i), .hdb3_i(hdb3_i),
        .inv_pol_i(inv_pol_i), .mute_en_i(mute_en_i), .sig_lost_i(sig_lost_i),
        .alm_test_n_i(alm_test_n_i), .rclk_o(rclk_o), .rd_pos_o(rd_pos_o),
        .rd_neg_o(rd_neg_o), .los_n_o(los_n_o), .loc_n_o(loc_n_o)
    );

    // [5:4] symbol (01 positive mark, 10 negative mark, 00 zero)
    // [3:2] HDB3 {data, violation}   [1:0] AMI {data, violation}
    localparam int NVEC = 24;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b011010, 6'b101010, 6'b000000, 6'b000000, 6'b000000, 6'b100011,
        6'b011010, 6'b101010, 6'b010010, 6'b000000, 6'b000000, 6'b010011,
        6'b101010, 6'b101111, 6'b011010, 6'b000000, 6'b011111, 6'b000000,
        6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rclk_i = 1'b0; rx_pos_i = 1'b0; rx_neg_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drive_bit(input logic p, input logic n);
        @(negedge clk);
        rclk_i = 1'b1; rx_pos_i = p; rx_neg_i = n;
        repeat (3) @(negedge clk);
        rclk_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // mode 0 HDB3, 1 AMI, 2 dual, 3 dual inverted, 4 HDB3 with alarm and inv_pol
    task automatic run_table(input int mode);
        int   lat;
        logic ep, en;
        dual_rail_i  = (mode == 2 || mode == 3);
        hdb3_i       = (mode != 1);
        inv_pol_i    = (mode == 3 || mode == 4);
        alm_test_n_i = (mode != 4);
        do_reset();
        lat = (mode == 3) ? 4 : 3;
        for (int k = 0; k < NVEC; k++) begin
            drive_bit(VEC[k][4], VEC[k][5]);
            if (k >= lat) begin
                case (mode)
                    0: begin ep = VEC[k-lat][3]; en = VEC[k-lat][2];
                             check("R3 R4 R2 hdb3 data", rd_pos_o, ep);
                             check("R4 hdb3 violation", rd_neg_o, en); end
                    1: begin ep = VEC[k-lat][1]; en = VEC[k-lat][0];
                             check("R5 ami data", rd_pos_o, ep);
                             check("R5 ami violation", rd_neg_o, en); end
                    2: begin ep = VEC[k-lat][4]; en = VEC[k-lat][5];
                             check("R1 R2 dual pos", rd_pos_o, ep);
                             check("R1 dual neg", rd_neg_o, en); end
                    3: begin ep = ~VEC[k-lat][4]; en = ~VEC[k-lat][5];
                             check("R6 R2 inverted pos", rd_pos_o, ep);
                             check("R6 inverted neg", rd_neg_o, en); end
                    default: begin ep = VEC[k-lat][3];
                             check("R11 R6 data under alarm", rd_pos_o, ep);
                             check("R11 violation forced", rd_neg_o, 1'b1);
                             check("R11 los low", los_n_o, 1'b0);
                             check("R11 loc low", loc_n_o, 1'b0); end
                endcase
            end
        end
        alm_test_n_i = 1'b1;
    endtask

    task automatic mute_check(input logic dual, input logic inv,
                              input logic eclk, input logic edat, input string req);
        dual_rail_i = dual; inv_pol_i = inv; hdb3_i = 1'b1;
        do_reset();
        drive_bit(1'b1, 1'b0);
        mute_en_i = 1'b1; sig_lost_i = 1'b1;
        @(negedge clk);
        check(req, rclk_o, eclk);
        check(req, rd_pos_o, edat);
        if (dual) check(req, rd_neg_o, edat);
        check("R10 loc low when muted", loc_n_o, 1'b0);
        check("R10 los low", los_n_o, 1'b0);
        mute_en_i = 1'b0; sig_lost_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R12 reset state
        check("R12 rd_pos idle", rd_pos_o, 1'b0);
        check("R12 rd_neg idle", rd_neg_o, 1'b0);
        check("R12 rclk idle", rclk_o, 1'b0);
        check("R12 los high", los_n_o, 1'b1);
        check("R12 loc high", loc_n_o, 1'b1);

        for (int m = 0; m < 5; m++) run_table(m);

        mute_check(1'b1, 1'b0, 1'b1, 1'b0, "R7 mute dual");
        mute_check(1'b1, 1'b1, 1'b0, 1'b1, "R8 mute dual inverted");
        mute_check(1'b0, 1'b0, 1'b1, 1'b0, "R9 mute single");

        // R10: loss of signal without muting leaves loc high
        sig_lost_i = 1'b1;
        @(negedge clk);
        check("R10 los follows loss", los_n_o, 1'b0);
        check("R10 loc stays high unmuted", loc_n_o, 1'b1);
        sig_lost_i = 1'b0;
        @(negedge clk);
        check("R10 los released", los_n_o, 1'b1);

        // R11: alarm wins over muting on the violation output in single-rail
        dual_rail_i = 1'b0; mute_en_i = 1'b1; sig_lost_i = 1'b1; alm_test_n_i = 1'b0;
        @(negedge clk);
        check("R11 violation over mute", rd_neg_o, 1'b1);
        check("R9 data muted under alarm", rd_pos_o, 1'b0);
        mute_en_i = 1'b0; sig_lost_i = 1'b0; alm_test_n_i = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule